// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block gathers a set of level-type interrupt inputs and presents them on a small number of interrupt request lines toward a host processor. Each raw input first passes through a two-flop synchronizer. A per-source polarity bit then turns it into an "active" condition. While a source is active, it latches a pending flag in every line's control register. Each line forwards a pending source to its output only when that source's enable bit is set in that line's register.

Software uses a 32-bit word-addressed register port. Word 0 is the polarity register. Word n+1 is the control register of line n. In a line register, the enable bits sit in the low half and the pending flags sit in the upper half. A handler reads the pending flags, services a source and writes 1 to that flag to acknowledge it. One write can replace the enables and acknowledge flags at the same time. The defaults are nine sources and three lines.

Top module: `lvl_irq_router`

## Requirements
- R1: While reset is held, the polarity register reads 0, every line register reads 0 and all line outputs are low.
- R2: Polarity bit k (word 0, bit k) set to 1 makes source k active when its input is high. Set to 0, source k is active when its input is low. Reset leaves every source active-low.
- R3: A change on a source input reaches the pending flags on the third rising edge after it is applied: two synchronizer flops, then the pending register.
- R4: A pending flag stays set after its source goes inactive, until software acknowledges it.
- R5: Writing 1 to bit 16+k of a line register clears pending flag k of that line. Writing 0 to that bit leaves the flag unchanged.
- R6: If a source is still active when it is acknowledged, its flag reads clear after the write edge and sets again on the next edge.
- R7: Line output n is driven only by sources whose enable bit k (bits 8:0) is set in line n's register. Pending flags read back whether or not the source is enabled.
- R8: Each line output is registered and active high. It rises or falls on the edge after the one where pending-and-enabled changes.
- R9: A single line write loads the enable field from bits 8:0 and acknowledges flags from bits 24:16 in the same edge.
- R10: Bits 31:9 of word 0, and bits 15:9 and 31:25 of each line register, read as zero and ignore writes.
- R11: The lines keep separate enable and pending state. A write to line n's register changes only line n.
- R12: Word address 0 selects the polarity register. Word address n+1 (byte offset 4+4n) selects line n. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC (9) | Raw interrupt source levels, asynchronous |
| wr_en_i | input | 1 | Register write strobe, one word per cycle |
| addr_i | input | ADDR_W (2) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | NUM_LINE (3) | Interrupt request lines, active high |

## Verification
Each result is due a fixed number of edges after its stimulus:
- A register write shows on read-back after one edge.
- A source change shows in the pending flags after three edges.
- A line output follows pending-and-enabled one edge after that.
- A re-assertion after an acknowledge appears one edge after the write edge.

The bench drives inputs just after a falling edge. It checks outputs at the following falling edge and reads the combinational register port one time step after setting the address. A cycle-accurate model in bench functions advances on the same edges. Directed checks therefore count exact edges to each expected value, and random traffic is compared on every cycle.

// File: rtl/lvl_irq_router_pkg.sv
package lvl_irq_router_pkg;
    localparam int unsigned DEF_NUM_SRC  = 9;
    localparam int unsigned DEF_NUM_LINE = 3;
    localparam int unsigned REG_W        = 32;
    localparam int unsigned PEND_LSB     = 16;
endpackage

// File: rtl/lvl_irq_src_cond.sv
module lvl_irq_src_cond #(
    parameter int unsigned NUM_SRC = 9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] pol_i,
    output logic [NUM_SRC-1:0] active_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // polarity 1: high is active; polarity 0: low is active
    assign active_o = ~(st_q.s2 ^ pol_i);
endmodule

// File: rtl/lvl_irq_line_ctl.sv
module lvl_irq_line_ctl #(
    parameter int unsigned NUM_SRC = 9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] active_i,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    input  logic [NUM_SRC-1:0] ack_wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] pend;
        logic               irq;
    } line_t;

    line_t              st_d, st_q;
    logic [NUM_SRC-1:0] ack;

    always_comb begin
        st_d = st_q;
        ack  = '0;
        if (wr_i) begin
            st_d.en = en_wdata_i;
            ack     = ack_wdata_i;
        end
        // acknowledge wins this edge; a still-active source re-latches next edge
        st_d.pend = (st_q.pend | active_i) & ~ack;
        st_d.irq  = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;

    // R5
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((pend_o & $past(ack_wdata_i)) == '0));

    // R4
    pend_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> (($past(pend_o) & ~pend_o) == '0));

    // R6
    active_latches_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> ((pend_o & $past(active_i)) == $past(active_i)));

    // R9
    en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (en_o == $past(en_wdata_i)));

    // R7
    masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_o == '0) |=> !irq_o);
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
    import lvl_irq_router_pkg::*;
#(
    parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
    parameter int unsigned NUM_LINE = DEF_NUM_LINE,
    parameter int unsigned ADDR_W   = $clog2(NUM_LINE + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [REG_W-1:0]    wdata_i,
    output logic [REG_W-1:0]    rdata_o,
    output logic [NUM_LINE-1:0] irq_o
);
    localparam int unsigned NUM_WORDS = NUM_LINE + 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] pol;
    } cfg_t;

    cfg_t               cfg_d, cfg_q;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] line_en   [NUM_LINE];
    logic [NUM_SRC-1:0] line_pend [NUM_LINE];
    logic [REG_W-1:0]   word_rd   [NUM_WORDS];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i && (addr_i == '0)) cfg_d.pol = wdata_i[NUM_SRC-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    lvl_irq_src_cond #(.NUM_SRC(NUM_SRC)) u_cond (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .raw_i    (src_i),
        .pol_i    (cfg_q.pol),
        .active_o (active)
    );

    always_comb begin
        word_rd[0]                = '0;
        word_rd[0][NUM_SRC-1:0]   = cfg_q.pol;
    end

    for (genvar n = 0; n < NUM_LINE; n++) begin : g_line
        logic line_wr;
        assign line_wr = wr_en_i && (int'(addr_i) == n + 1);

        lvl_irq_line_ctl #(.NUM_SRC(NUM_SRC)) u_line (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .active_i    (active),
            .wr_i        (line_wr),
            .en_wdata_i  (wdata_i[NUM_SRC-1:0]),
            .ack_wdata_i (wdata_i[PEND_LSB +: NUM_SRC]),
            .en_o        (line_en[n]),
            .pend_o      (line_pend[n]),
            .irq_o       (irq_o[n])
        );

        always_comb begin
            word_rd[n+1]                          = '0;
            word_rd[n+1][NUM_SRC-1:0]             = line_en[n];
            word_rd[n+1][PEND_LSB +: NUM_SRC]     = line_pend[n];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (int'(addr_i) < NUM_WORDS) rdata_o = word_rd[addr_i];
    end

    // R2
    pol_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == '0) |=> (cfg_q.pol == $past(wdata_i[NUM_SRC-1:0])));
endmodule

// File: tb/lvl_irq_router_test.sv
module lvl_irq_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 9;
    localparam int NL = 3;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NS-1:0] src = '0;
    logic          wr_en = 0;
    logic [1:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NL-1:0] irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model
    logic [NS-1:0] m_s1, m_s2, m_pol;
    logic [NS-1:0] m_en [NL];
    logic [NS-1:0] m_pend [NL];
    logic [NL-1:0] m_irq;

    lvl_irq_router uut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_read(input logic [1:0] a);
        logic [31:0] v = '0;
        if (a == 0) v[NS-1:0] = m_pol;
        else begin
            v[NS-1:0]   = m_en[a-1];
            v[16 +: NS] = m_pend[a-1];
        end
        return v;
    endfunction

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_pol = '0; m_irq = '0;
        for (int i = 0; i < NL; i++) begin m_en[i] = '0; m_pend[i] = '0; end
    endtask

    task automatic model_step(input logic w, input logic [1:0] a, input logic [31:0] d,
                              input logic [NS-1:0] s);
        logic [NS-1:0] act = ~(m_s2 ^ m_pol);
        logic [NS-1:0] ack;
        for (int i = 0; i < NL; i++) begin
            m_irq[i] = |(m_pend[i] & m_en[i]);
            ack = (w && a == i + 1) ? d[16 +: NS] : '0;
            m_pend[i] = (m_pend[i] | act) & ~ack;
            if (w && a == i + 1) m_en[i] = d[NS-1:0];
        end
        if (w && a == 0) m_pol = d[NS-1:0];
        m_s2 = m_s1;
        m_s1 = s;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d);
        wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        if (rst_n) model_step(w, a, d, src);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; src = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        rst_n = 0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) rd_chk("R1 reset register", 2'(a), 32'h0);
        check("R1 reset irq", 32'(irq), 32'h0);
        rst_n = 1;

        // R2 default active-low with inputs low: all flags latch
        cyc(0, 0, 0); cyc(0, 0, 0);
        rd_chk("R2 active-low default", 2'd1, 32'h01FF_0000);

        // R10 reserved bits of polarity word
        cyc(1, 0, 32'hFFFF_FFFF);
        rd_chk("R10 reserved polarity bits", 2'd0, 32'h0000_01FF);

        // R5 acknowledge line 0; R11 line 1 untouched
        cyc(1, 1, 32'h01FF_0000);
        rd_chk("R5 w1c clears", 2'd1, 32'h0);
        rd_chk("R11 other line kept", 2'd2, 32'h01FF_0000);
        cyc(1, 2, 32'h0);
        rd_chk("R5 zero write no effect", 2'd2, 32'h01FF_0000);

        // R8 enable source 3 on line 2 (word 3)
        cyc(1, 3, 32'h0000_0008);
        check("R8 output not yet", 32'(irq), 32'h0);
        rd_chk("R12 line 2 at word 3", 2'd3, 32'h01FF_0008);
        cyc(0, 0, 0);
        check("R8 R7 only enabled line", 32'(irq), 32'h4);

        // R9 combined enable + acknowledge
        cyc(1, 3, 32'h01FF_0008);
        rd_chk("R9 combined write", 2'd3, 32'h0000_0008);
        cyc(0, 0, 0);
        check("R9 output drops", 32'(irq), 32'h0);

        // R3 latency with active-high source 3
        src[3] = 1'b1;
        cyc(0, 0, 0); cyc(0, 0, 0);
        rd_chk("R3 not yet pending", 2'd3, 32'h0000_0008);
        cyc(0, 0, 0);
        rd_chk("R3 pending on third edge", 2'd3, 32'h0008_0008);
        check("R8 output one edge later", 32'(irq), 32'h0);
        cyc(0, 0, 0);
        check("R8 output asserted", 32'(irq), 32'h4);
        rd_chk("R7 pending visible while disabled", 2'd1, 32'h0008_0000);

        // R6 acknowledge while active
        cyc(1, 1, 32'h0008_0000);
        rd_chk("R6 cleared on write edge", 2'd1, 32'h0);
        cyc(0, 0, 0);
        rd_chk("R6 re-latched next edge", 2'd1, 32'h0008_0000);

        // R4 hold after source inactive
        src[3] = 1'b0;
        repeat (4) cyc(0, 0, 0);
        rd_chk("R4 flag held", 2'd3, 32'h0008_0008);
        cyc(1, 3, 32'h0008_0008);
        cyc(0, 0, 0);
        rd_chk("R4 stays clear after ack", 2'd3, 32'h0000_0008);

        // random phase against model
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic w;
            logic [1:0] a;
            logic [31:0] d;
            if ($urandom_range(0, 7) == 0) src = NS'($urandom);
            w = ($urandom_range(0, 3) == 0);
            a = 2'($urandom);
            d = $urandom;
            if ($urandom_range(0, 1) == 0) d[16 +: NS] = '0;
            cyc(w, a, d);
            check("R8 random irq", 32'(irq), 32'(m_irq));
            a = 2'($urandom);
            rd_chk("R12 random readback", a, model_read(a));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule